// File: doc/BRIEF.md
# Shadowed Register Access Sequencer

This block sits between a host request port and a two-channel serial controller whose registers are reached through an indirect pointer scheme. The host asks for a register by a 6-bit id, a channel, a direction and an optional "skip trailing wait" flag. The sequencer turns each request into the short series of byte-wide controller cycles it needs, keeps timing between those cycles legal, and reports completion with a one-cycle done strobe, read data and an error flag.

The controller's configuration registers cannot be read back, so the sequencer keeps a copy of every value written to them and answers reads of those ids from that copy without touching the controller. It also handles the irregular cases itself. One register is shared by both channels. Two registers carry one-shot command bits that must not be remembered. An option register shares its pointer with a sync register and is chosen by bit 0 of register 15. Two status reads only make sense on a fixed channel.

Ids 0 to 15 are write registers 0 to 15. Id 16+n is read register n. Id 33 is the option register that shares pointer 7. Channel 0 is channel A and channel 1 is channel B. Every controller cycle is a single-clock strobe on one of four lines: control port or data port, for channel A or channel B. `bus_write` gives the direction of the cycle and `bus_wdata` its byte. `bus_rdata` is sampled during a read strobe.

Top module: `regseq_top`

## Requirements
- R1: `req_ready` is 1 only while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both 1. Each request gives exactly one `rsp_done` pulse. For a request that uses the bus, `req_ready` is 0 from the cycle after acceptance until the cycle in which `rsp_done` is 1.
- R2: A pointer access is two control-port cycles on the target channel. The first is a write of the pointer value (id bits 3:0). The second writes the byte or reads it. At most one strobe is high in any cycle.
- R3: Any two bus strobes, including strobes from different requests, are at least GAP_CLKS cycles apart. Within one request, consecutive strobes are exactly GAP_CLKS apart.
- R4: With `req_nodelay` 0, `rsp_done` comes GAP_CLKS cycles after the last strobe. With `req_nodelay` 1 it comes one cycle after the last strobe.
- R5: A write to id 0 is a single control-port write of the byte. A write to id 8 is a single data-port write. A read of id 24 is a single data-port read. A read of id 16 is a single control-port read.
- R6: A write to id 9 is reduced to bits 5:0 and a write to id 14 to bits 4:0. The reduced value is both sent and remembered.
- R7: The copy for id 9 is shared by both channels. Every other remembered register is held separately per channel.
- R8: Before a write to id 7, if bit 0 of the channel's register-15 copy is 1, that bit is cleared and register 15 is rewritten (pointer 15, new value). Before a write to id 33, if the bit is 0, it is set and register 15 is rewritten. Both writes then use pointer 7. The id 33 value is remembered apart from id 7.
- R9: A read of id 1 to 7, 9 to 15 or 33 returns the remembered value with `rsp_done` in the cycle after acceptance, and no strobe.
- R10: A read of id 19 always runs on channel A with pointer 3. A read of id 18 always runs on channel B with pointer 2. The requested channel does not matter for either.
- R11: An unsupported id gives `rsp_done` and `rsp_err` in the cycle after acceptance, and no strobe. For writes, the unsupported ids are 16 to 32 and 34 to 63. For reads, they are 0, 8, 20, 21, 25, 27 to 32 and 34 to 63.
- R12: After reset, `req_ready` is 1, no strobe or done is high, and every remembered register reads as 0.
- R13: `rsp_rdata` of a bus read equals `bus_rdata` during that request's read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_chan | input | 1 | Target channel, 0 = A, 1 = B |
| req_id | input | 6 | Register id |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nodelay | input | 1 | Omit trailing recovery wait |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read result, valid with rsp_done |
| rsp_err | output | 1 | Unsupported id, valid with rsp_done |
| bus_ctrl_stb | output | 2 | Control-port cycle strobe, one bit per channel |
| bus_data_stb | output | 2 | Data-port cycle strobe, one bit per channel |
| bus_write | output | 1 | Direction of the current cycle, 1 = write |
| bus_wdata | output | 8 | Byte driven during a write cycle |
| bus_rdata | input | 8 | Byte returned during a read cycle |

## Verification
The assertions check the following on every cycle:
- At most one strobe is high at a time.
- The recovery spacing holds between any two strobes.
- Shadow reads and out-of-range ids finish in one cycle with no bus traffic.
- A pointer write locks out new requests until it finishes.
- The error flag never appears without done.

The exact byte sequences need the bench's directed scenarios, because they depend on earlier writes. These cover the register-15 select rewrites, the masked values, the shared versus per-channel copies, channel steering and the trailing-delay latency.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
    localparam int DW      = 8;
    localparam int ID_W    = 6;
    localparam int NCH     = 2;
    localparam int SLOTS   = 16;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int MAX_OPS = 4;
    localparam int OPS_W   = $clog2(MAX_OPS + 1);

    // register ids with special handling
    localparam logic [ID_W-1:0] ID_CMD    = 6'd0;
    localparam logic [ID_W-1:0] ID_SYNC   = 6'd7;
    localparam logic [ID_W-1:0] ID_TXD    = 6'd8;
    localparam logic [ID_W-1:0] ID_SHARED = 6'd9;
    localparam logic [ID_W-1:0] ID_CLKCMD = 6'd14;
    localparam logic [ID_W-1:0] ID_STAT   = 6'd16;
    localparam logic [ID_W-1:0] ID_VEC    = 6'd18;
    localparam logic [ID_W-1:0] ID_PEND   = 6'd19;
    localparam logic [ID_W-1:0] ID_RXD    = 6'd24;
    localparam logic [ID_W-1:0] ID_OPT    = 6'd33;

    localparam logic [SLOT_W-1:0] SLOT_SEL = 4'd15;
    localparam logic [SLOT_W-1:0] SLOT_OPT = 4'd8;
    localparam logic [SLOT_W-1:0] SLOT_SHR = 4'd9;
    localparam logic [SLOT_W-1:0] PTR_SYNC = 4'd7;

    localparam logic [DW-1:0] KEEP_SHARED = 8'h3F;
    localparam logic [DW-1:0] KEEP_CLKCMD = 8'h1F;

    typedef struct packed {
        logic          to_data;
        logic          wr;
        logic [DW-1:0] val;
    } bus_op_t;

    typedef enum logic [1:0] {K_BUS, K_SHADOW, K_ERR} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} state_e;

    typedef struct packed {
        state_e                       st;
        bus_op_t [MAX_OPS-1:0]        ops;
        logic [OPS_W-1:0]             n_ops;
        logic [OPS_W-1:0]             idx;
        logic                         chan;
        logic                         nodelay;
        logic                         stb;
        bus_op_t                      cur;
        logic [DW-1:0]                rdata;
        logic                         done;
        logic                         err;
    } seq_t;
endpackage

// File: rtl/regseq_gap_timer.sv
module regseq_gap_timer #(
    parameter int GAP_CLKS = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);
    localparam int CW = $clog2(GAP_CLKS + 1);
    localparam logic [CW-1:0] RELOAD = CW'(GAP_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/regseq_shadow.sv
module regseq_shadow
    import regseq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      a_we,
    input  logic                      a_chan,
    input  logic [SLOT_W-1:0]         a_slot,
    input  logic [DW-1:0]             a_val,
    input  logic                      s_we,
    input  logic                      s_chan,
    input  logic [DW-1:0]             s_val,
    input  logic                      rd_chan,
    input  logic [SLOT_W-1:0]         rd_slot,
    output logic [DW-1:0]             rd_val,
    output logic [NCH-1:0][DW-1:0]    sel_all
);
    logic [NCH-1:0][SLOTS-1:0][DW-1:0] mem_d, mem_q;
    logic a_eff, rd_eff;

    // the shared slot always lives in channel 0's storage
    assign a_eff  = (a_slot  == SLOT_SHR) ? 1'b0 : a_chan;
    assign rd_eff = (rd_slot == SLOT_SHR) ? 1'b0 : rd_chan;

    always_comb begin
        mem_d = mem_q;
        if (s_we) mem_d[s_chan][SLOT_SEL] = s_val;
        if (a_we) mem_d[a_eff][a_slot]    = a_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_val = mem_q[rd_eff][rd_slot];

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        assign sel_all[c] = mem_q[c][SLOT_SEL];
    end
endmodule

// File: rtl/regseq_decode.sv
module regseq_decode
    import regseq_pkg::*;
(
    input  logic [ID_W-1:0]          id,
    input  logic                     is_write,
    input  logic [DW-1:0]            wdata,
    input  logic                     chan,
    input  logic [DW-1:0]            sel_cur,
    output kind_e                    kind,
    output bus_op_t [MAX_OPS-1:0]    ops,
    output logic [OPS_W-1:0]         n_ops,
    output logic                     bus_chan,
    output logic                     sh_we,
    output logic [SLOT_W-1:0]        sh_slot,
    output logic [DW-1:0]            sh_val,
    output logic                     sel_we,
    output logic [DW-1:0]            sel_val,
    output logic [SLOT_W-1:0]        rd_slot
);
    function automatic bus_op_t ptr_op(input logic [SLOT_W-1:0] n);
        bus_op_t o;
        o.to_data = 1'b0;
        o.wr      = 1'b1;
        o.val     = {{(DW-SLOT_W){1'b0}}, n};
        return o;
    endfunction

    function automatic bus_op_t mk_op(input logic dp, input logic w, input logic [DW-1:0] v);
        bus_op_t o;
        o.to_data = dp;
        o.wr      = w;
        o.val     = v;
        return o;
    endfunction

    logic          want_opt;
    logic [DW-1:0] kept;

    always_comb begin
        kind     = K_ERR;
        ops      = '0;
        n_ops    = '0;
        bus_chan = chan;
        sh_we    = 1'b0;
        sh_slot  = id[SLOT_W-1:0];
        sh_val   = wdata;
        sel_we   = 1'b0;
        sel_val  = sel_cur;
        rd_slot  = id[SLOT_W-1:0];
        want_opt = (id == ID_OPT);
        kept     = wdata;
        if (id == ID_SHARED) kept = wdata & KEEP_SHARED;
        if (id == ID_CLKCMD) kept = wdata & KEEP_CLKCMD;

        if (is_write) begin
            if (id == ID_CMD) begin
                kind   = K_BUS;
                ops[0] = mk_op(1'b0, 1'b1, wdata);
                n_ops  = 3'd1;
            end else if (id == ID_TXD) begin
                kind   = K_BUS;
                ops[0] = mk_op(1'b1, 1'b1, wdata);
                n_ops  = 3'd1;
            end else if (id == ID_SYNC || id == ID_OPT) begin
                kind    = K_BUS;
                sh_we   = 1'b1;
                sh_slot = want_opt ? SLOT_OPT : PTR_SYNC;
                if (sel_cur[0] != want_opt) begin
                    sel_we  = 1'b1;
                    sel_val = {sel_cur[DW-1:1], want_opt};
                    ops[0]  = ptr_op(SLOT_SEL);
                    ops[1]  = mk_op(1'b0, 1'b1, {sel_cur[DW-1:1], want_opt});
                    ops[2]  = ptr_op(PTR_SYNC);
                    ops[3]  = mk_op(1'b0, 1'b1, wdata);
                    n_ops   = 3'd4;
                end else begin
                    ops[0]  = ptr_op(PTR_SYNC);
                    ops[1]  = mk_op(1'b0, 1'b1, wdata);
                    n_ops   = 3'd2;
                end
            end else if (id < ID_W'(SLOTS)) begin
                kind   = K_BUS;
                sh_we  = 1'b1;
                sh_val = kept;
                ops[0] = ptr_op(id[SLOT_W-1:0]);
                ops[1] = mk_op(1'b0, 1'b1, kept);
                n_ops  = 3'd2;
            end
        end else begin
            if (id == ID_OPT) begin
                kind    = K_SHADOW;
                rd_slot = SLOT_OPT;
            end else if (id != ID_CMD && id != ID_TXD && id < ID_W'(SLOTS)) begin
                kind    = K_SHADOW;
            end else if (id == ID_STAT) begin
                kind   = K_BUS;
                ops[0] = mk_op(1'b0, 1'b0, '0);
                n_ops  = 3'd1;
            end else if (id == ID_RXD) begin
                kind   = K_BUS;
                ops[0] = mk_op(1'b1, 1'b0, '0);
                n_ops  = 3'd1;
            end else if (id == 6'd17 || id == 6'd22 || id == 6'd23 || id == 6'd26
                         || id == ID_PEND || id == ID_VEC) begin
                kind   = K_BUS;
                ops[0] = ptr_op(id[SLOT_W-1:0]);
                ops[1] = mk_op(1'b0, 1'b0, '0);
                n_ops  = 3'd2;
                if (id == ID_PEND) bus_chan = 1'b0;
                if (id == ID_VEC)  bus_chan = 1'b1;
            end
        end
    end
endmodule

// File: rtl/regseq_top.sv
module regseq_top
    import regseq_pkg::*;
#(
    parameter int GAP_CLKS = 44
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_chan,
    input  logic [5:0]     req_id,
    input  logic [7:0]     req_wdata,
    input  logic           req_write,
    input  logic           req_nodelay,
    output logic           rsp_done,
    output logic [7:0]     rsp_rdata,
    output logic           rsp_err,
    output logic [1:0]     bus_ctrl_stb,
    output logic [1:0]     bus_data_stb,
    output logic           bus_write,
    output logic [7:0]     bus_wdata,
    input  logic [7:0]     bus_rdata
);
    seq_t r_d, r_q;

    logic                   accept;
    logic                   gap_idle;
    logic                   t_load;
    kind_e                  dec_kind;
    bus_op_t [MAX_OPS-1:0]  dec_ops;
    logic [OPS_W-1:0]       dec_n;
    logic                   dec_chan;
    logic                   dec_sh_we, dec_sel_we;
    logic [SLOT_W-1:0]      dec_sh_slot, dec_rd_slot;
    logic [DW-1:0]          dec_sh_val, dec_sel_val;
    logic [DW-1:0]          sh_rd_val;
    logic [NCH-1:0][DW-1:0] sel_all;

    assign req_ready = (r_q.st == S_IDLE);
    assign accept    = req_valid && req_ready;

    regseq_decode u_dec (
        .id       (req_id),
        .is_write (req_write),
        .wdata    (req_wdata),
        .chan     (req_chan),
        .sel_cur  (sel_all[req_chan]),
        .kind     (dec_kind),
        .ops      (dec_ops),
        .n_ops    (dec_n),
        .bus_chan (dec_chan),
        .sh_we    (dec_sh_we),
        .sh_slot  (dec_sh_slot),
        .sh_val   (dec_sh_val),
        .sel_we   (dec_sel_we),
        .sel_val  (dec_sel_val),
        .rd_slot  (dec_rd_slot)
    );

    regseq_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (accept && dec_sh_we),
        .a_chan  (req_chan),
        .a_slot  (dec_sh_slot),
        .a_val   (dec_sh_val),
        .s_we    (accept && dec_sel_we),
        .s_chan  (req_chan),
        .s_val   (dec_sel_val),
        .rd_chan (req_chan),
        .rd_slot (dec_rd_slot),
        .rd_val  (sh_rd_val),
        .sel_all (sel_all)
    );

    regseq_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .idle  (gap_idle)
    );

    always_comb begin
        r_d      = r_q;
        r_d.stb  = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        t_load   = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (accept) begin
                    unique case (dec_kind)
                        K_SHADOW: begin
                            r_d.rdata = sh_rd_val;
                            r_d.done  = 1'b1;
                        end
                        K_ERR: begin
                            r_d.rdata = '0;
                            r_d.done  = 1'b1;
                            r_d.err   = 1'b1;
                        end
                        default: begin
                            r_d.st      = S_RUN;
                            r_d.ops     = dec_ops;
                            r_d.n_ops   = dec_n;
                            r_d.idx     = '0;
                            r_d.chan    = dec_chan;
                            r_d.nodelay = req_nodelay;
                        end
                    endcase
                end
            end
            S_RUN: begin
                if (r_q.idx < r_q.n_ops && gap_idle) begin
                    r_d.stb = 1'b1;
                    r_d.cur = r_q.ops[r_q.idx[1:0]];
                    r_d.idx = r_q.idx + 1'b1;
                    t_load  = 1'b1;
                end else if (r_q.stb && r_q.idx == r_q.n_ops) begin
                    if (!r_q.cur.wr) r_d.rdata = bus_rdata;
                    if (r_q.nodelay || gap_idle) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st   = S_TAIL;
                    end
                end
            end
            S_TAIL: begin
                if (gap_idle) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q    <= r_d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_stb
        assign bus_ctrl_stb[c] = r_q.stb && !r_q.cur.to_data && (r_q.chan == c[0]);
        assign bus_data_stb[c] = r_q.stb &&  r_q.cur.to_data && (r_q.chan == c[0]);
    end

    assign bus_write = r_q.stb && r_q.cur.wr;
    assign bus_wdata = r_q.cur.val;
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;
    assign rsp_err   = r_q.err;
endmodule

// File: rtl/regseq_checker.sv
module regseq_checker #(
    parameter int GAP_CLKS = 44
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [5:0] req_id,
    input logic       req_write,
    input logic       rsp_done,
    input logic       rsp_err,
    input logic [1:0] bus_ctrl_stb,
    input logic [1:0] bus_data_stb
);
    localparam int SW = $clog2(GAP_CLKS + 1) + 1;
    localparam logic [SW-1:0] SAT = SW'(GAP_CLKS);

    logic          any_stb, acc;
    logic [SW-1:0] since_q;

    assign any_stb = |{bus_ctrl_stb, bus_data_stb};
    assign acc     = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             since_q <= SAT;
        else if (any_stb)       since_q <= SW'(1);
        else if (since_q < SAT) since_q <= since_q + 1'b1;
    end

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_ctrl_stb, bus_data_stb}));

    assert_recovery_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> since_q >= SAT);

    assert_shadow_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && (req_id inside {[6'd1:6'd7], [6'd9:6'd15], 6'd33}))
        |=> (rsp_done && !rsp_err && !any_stb));

    assert_bad_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_id >= 6'd34) |=> (rsp_done && rsp_err && !any_stb));

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    assert_busy_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && (req_id inside {[6'd1:6'd6]})) |=> (!req_ready && !rsp_done));
endmodule

bind regseq_top regseq_checker #(.GAP_CLKS(GAP_CLKS)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_id       (req_id),
    .req_write    (req_write),
    .rsp_done     (rsp_done),
    .rsp_err      (rsp_err),
    .bus_ctrl_stb (bus_ctrl_stb),
    .bus_data_stb (bus_data_stb)
);

// File: tb/tb_regseq_top.sv
`timescale 1ns/1ps
module tb_regseq_top;
    localparam int GAP = 44;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_chan = 1'b0, req_write = 1'b0, req_nodelay = 1'b0;
    logic [5:0] req_id = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, rsp_done, rsp_err, bus_write;
    logic [7:0] rsp_rdata, bus_wdata, bus_rdata;
    logic [1:0] bus_ctrl_stb, bus_data_stb;
    logic [7:0] rd_base = 8'h3C;

    always #5 clk = ~clk;

    // controller model: read byte depends on channel and port
    assign bus_rdata = rd_base ^ ((bus_ctrl_stb[1] | bus_data_stb[1]) ? 8'h80 : 8'h00)
                               ^ ((|bus_data_stb) ? 8'h40 : 8'h00);

    regseq_top #(.GAP_CLKS(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_id(req_id), .req_wdata(req_wdata), .req_write(req_write),
        .req_nodelay(req_nodelay), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_ctrl_stb(bus_ctrl_stb), .bus_data_stb(bus_data_stb), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0, done_cnt = 0, gap_viol = 0, last_stb = -1000;
    int l_n = 0, d_cyc = 0, acc_cyc = 0, dn = 0;
    int l_cyc [8];
    int l_op  [8];
    logic d_err;
    logic [7:0] d_data;
    logic rdy_after;
    bit finished = 0;

    function automatic int op(input bit ch, input bit dp, input bit wr, input logic [7:0] v);
        return int'({ch, dp, wr, v});
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (|{bus_ctrl_stb, bus_data_stb}) begin
            if (l_n < 8) begin
                l_cyc[l_n] = cyc;
                l_op[l_n]  = op(bus_ctrl_stb[1] | bus_data_stb[1], |bus_data_stb,
                                bus_write, bus_write ? bus_wdata : 8'h00);
            end
            l_n++;
            if (cyc - last_stb < GAP) gap_viol++;
            last_stb = cyc;
        end
        if (rsp_done) begin
            done_cnt++;
            d_cyc  = cyc;
            d_err  = rsp_err;
            d_data = rsp_rdata;
        end
        if (cyc > 150000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    task automatic do_req(input logic ch, input logic [5:0] id, input logic [7:0] wd,
                          input logic wr, input logic nd);
        int start;
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        l_n = 0; start = done_cnt;
        req_valid = 1; req_chan = ch; req_id = id; req_wdata = wd;
        req_write = wr; req_nodelay = nd;
        @(posedge clk);
        acc_cyc = cyc + 1;
        #1;
        req_valid = 0;
        rdy_after = req_ready;
        while (done_cnt == start) begin @(posedge clk); #1; end
        dn = done_cnt - start;
    endtask

    task automatic rd_shadow(input logic ch, input logic [5:0] id, input logic [7:0] exp, input string rq);
        do_req(ch, id, 8'h00, 1'b0, 1'b0);
        chk(d_data == exp, rq, d_data, exp);
        chk(l_n == 0 && d_cyc == acc_cyc, {rq, " immediate"}, l_n, 0);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R12 ready", req_ready, 1);
        chk(rsp_done == 1'b0 && bus_ctrl_stb == 0 && bus_data_stb == 0, "R12 quiet", rsp_done, 0);
        rd_shadow(1'b0, 6'd3, 8'h00, "R12 shadow zero ch A");
        rd_shadow(1'b1, 6'd33, 8'h00, "R12 shadow zero opt");
    endtask

    task automatic t_normal;
        do_req(1'b0, 6'd3, 8'h5A, 1'b1, 1'b0);
        chk(rdy_after == 1'b0, "R1 busy", rdy_after, 0);
        chk(dn == 1, "R1 one done", dn, 1);
        chk(l_n == 2, "R2 op count", l_n, 2);
        chk(l_op[0] == op(0, 0, 1, 8'h03), "R2 pointer", l_op[0], op(0, 0, 1, 8'h03));
        chk(l_op[1] == op(0, 0, 1, 8'h5A), "R2 value", l_op[1], op(0, 0, 1, 8'h5A));
        chk(l_cyc[1] - l_cyc[0] == GAP, "R3 spacing", l_cyc[1] - l_cyc[0], GAP);
        chk(d_cyc - l_cyc[1] == GAP, "R4 trailing wait", d_cyc - l_cyc[1], GAP);
        chk(d_err == 1'b0, "R11 no err", d_err, 0);
        rd_shadow(1'b0, 6'd3, 8'h5A, "R9 shadow readback");
        rd_shadow(1'b1, 6'd3, 8'h00, "R7 per-channel copy");
    endtask

    task automatic t_nodelay;
        int prev;
        do_req(1'b1, 6'd5, 8'h11, 1'b1, 1'b1);
        chk(l_n == 2 && l_op[1] == op(1, 0, 1, 8'h11), "R2 ch B value", l_op[1], op(1, 0, 1, 8'h11));
        chk(d_cyc - l_cyc[1] == 1, "R4 skip wait", d_cyc - l_cyc[1], 1);
        prev = l_cyc[1];
        do_req(1'b1, 6'd10, 8'h22, 1'b1, 1'b0);
        chk(l_cyc[0] - prev >= GAP, "R3 across requests", l_cyc[0] - prev, GAP);
    endtask

    task automatic t_mask;
        do_req(1'b1, 6'd9, 8'hFF, 1'b1, 1'b0);
        chk(l_op[0] == op(1, 0, 1, 8'h09) && l_op[1] == op(1, 0, 1, 8'h3F),
            "R6 shared reg masked", l_op[1], op(1, 0, 1, 8'h3F));
        rd_shadow(1'b0, 6'd9, 8'h3F, "R7 shared copy");
        do_req(1'b0, 6'd14, 8'hFF, 1'b1, 1'b0);
        chk(l_op[0] == op(0, 0, 1, 8'h0E) && l_op[1] == op(0, 0, 1, 8'h1F),
            "R6 clock reg masked", l_op[1], op(0, 0, 1, 8'h1F));
        rd_shadow(1'b0, 6'd14, 8'h1F, "R6 masked shadow");
    endtask

    task automatic t_select;
        do_req(1'b0, 6'd15, 8'h81, 1'b1, 1'b0);
        do_req(1'b0, 6'd33, 8'h44, 1'b1, 1'b0);
        chk(l_n == 2 && l_op[0] == op(0, 0, 1, 8'h07) && l_op[1] == op(0, 0, 1, 8'h44),
            "R8 opt no rewrite", l_n, 2);
        rd_shadow(1'b0, 6'd33, 8'h44, "R8 opt shadow");
        do_req(1'b0, 6'd7, 8'h22, 1'b1, 1'b0);
        chk(l_n == 4, "R8 sync rewrite count", l_n, 4);
        chk(l_op[0] == op(0, 0, 1, 8'h0F) && l_op[1] == op(0, 0, 1, 8'h80),
            "R8 select cleared", l_op[1], op(0, 0, 1, 8'h80));
        chk(l_op[2] == op(0, 0, 1, 8'h07) && l_op[3] == op(0, 0, 1, 8'h22),
            "R8 sync write", l_op[3], op(0, 0, 1, 8'h22));
        rd_shadow(1'b0, 6'd15, 8'h80, "R8 select shadow cleared");
        rd_shadow(1'b0, 6'd7, 8'h22, "R8 sync shadow");
        do_req(1'b0, 6'd33, 8'h55, 1'b1, 1'b0);
        chk(l_n == 4 && l_op[1] == op(0, 0, 1, 8'h81) && l_op[3] == op(0, 0, 1, 8'h55),
            "R8 select set", l_op[1], op(0, 0, 1, 8'h81));
        rd_shadow(1'b0, 6'd33, 8'h55, "R8 opt separate");
        rd_shadow(1'b0, 6'd7, 8'h22, "R8 sync kept");
    endtask

    task automatic t_direct;
        do_req(1'b1, 6'd0, 8'h10, 1'b1, 1'b0);
        chk(l_n == 1 && l_op[0] == op(1, 0, 1, 8'h10), "R5 cmd direct", l_op[0], op(1, 0, 1, 8'h10));
        do_req(1'b0, 6'd8, 8'h77, 1'b1, 1'b0);
        chk(l_n == 1 && l_op[0] == op(0, 1, 1, 8'h77), "R5 tx data port", l_op[0], op(0, 1, 1, 8'h77));
        rd_base = 8'h3C;
        do_req(1'b1, 6'd24, 8'h00, 1'b0, 1'b0);
        chk(l_n == 1 && l_op[0] == op(1, 1, 0, 8'h00), "R5 rx data port", l_op[0], op(1, 1, 0, 8'h00));
        chk(d_data == (8'h3C ^ 8'hC0), "R13 rx data", d_data, 8'h3C ^ 8'hC0);
        do_req(1'b0, 6'd16, 8'h00, 1'b0, 1'b1);
        chk(l_n == 1 && l_op[0] == op(0, 0, 0, 8'h00), "R5 status direct", l_op[0], op(0, 0, 0, 8'h00));
        chk(d_data == 8'h3C, "R13 status data", d_data, 8'h3C);
    endtask

    task automatic t_steer;
        rd_base = 8'h15;
        do_req(1'b1, 6'd17, 8'h00, 1'b0, 1'b0);
        chk(l_n == 2 && l_op[0] == op(1, 0, 1, 8'h01) && l_op[1] == op(1, 0, 0, 8'h00),
            "R2 pointer read", l_op[0], op(1, 0, 1, 8'h01));
        chk(d_data == (8'h15 ^ 8'h80), "R13 pointer read data", d_data, 8'h15 ^ 8'h80);
        do_req(1'b1, 6'd19, 8'h00, 1'b0, 1'b0);
        chk(l_n == 2 && l_op[0] == op(0, 0, 1, 8'h03) && l_op[1] == op(0, 0, 0, 8'h00),
            "R10 pending on A", l_op[0], op(0, 0, 1, 8'h03));
        chk(d_data == 8'h15, "R10 pending data", d_data, 8'h15);
        do_req(1'b0, 6'd18, 8'h00, 1'b0, 1'b0);
        chk(l_n == 2 && l_op[0] == op(1, 0, 1, 8'h02) && l_op[1] == op(1, 0, 0, 8'h00),
            "R10 vector on B", l_op[0], op(1, 0, 1, 8'h02));
    endtask

    task automatic t_errors;
        do_req(1'b0, 6'd20, 8'hAA, 1'b1, 1'b0);
        chk(d_err == 1'b1 && l_n == 0 && d_cyc == acc_cyc, "R11 bad write id", d_err, 1);
        do_req(1'b1, 6'd8, 8'h00, 1'b0, 1'b0);
        chk(d_err == 1'b1 && l_n == 0 && d_cyc == acc_cyc, "R11 bad read id", d_err, 1);
        do_req(1'b0, 6'd40, 8'h00, 1'b0, 1'b0);
        chk(d_err == 1'b1 && l_n == 0, "R11 high read id", d_err, 1);
        do_req(1'b1, 6'd63, 8'h12, 1'b1, 1'b0);
        chk(d_err == 1'b1 && l_n == 0 && dn == 1, "R11 high write id", d_err, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_normal();
        t_nodelay();
        t_mask();
        t_select();
        t_direct();
        t_steer();
        t_errors();
        chk(gap_viol == 0, "R3 no short gaps", gap_viol, 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule